// File: doc/BRIEF.md
# Wiper Store/Restore Sequencer

This block owns a W-bit wiper register and a W-bit register that stands in for nonvolatile memory. It orders all transfers between them and from the command side: a write to the wiper, a direct write to the memory copy, a store (wiper into memory) and a restore (memory into wiper). Each memory-side operation holds a busy flag for its own duration, which is counted in clock ticks set by parameters. The tests can shorten these durations, and a real build sets them from the clock rate.

When power-on reset is released, the wiper sits at midscale while a restore phase runs. At the end of that phase the stored value is copied into the wiper. A hold-off window counted from reset release blocks any memory write, and the write-protect input blocks the same writes. Requests that are blocked, that arrive while busy, or that lose to a higher-priority request in the same cycle are dropped, and a one-cycle rejected pulse marks them. A small read-only array of tolerance bytes is fixed by parameter and can be read at any time.

Top module: `wiper_nv_sequencer`

## Requirements
- R1: While reset is held, the wiper reads midscale (only the MSB of W set), the memory copy reads NV_INIT (default midscale), busy is 1 and the rejected pulse is 0.
- R2: After reset release, busy stays 1 for exactly T_RESTORE rising edges. The wiper holds midscale throughout, and at the edge where busy falls the wiper takes the memory value.
- R3: A wiper write accepted while idle loads the wiper with the data at that edge and does not raise busy.
- R4: An accepted restore raises busy for exactly T_RESTORE edges and leaves the wiper unchanged while busy. When busy falls, the wiper equals the memory value. Neither write protect nor the hold-off blocks a restore.
- R5: An accepted store copies the wiper into memory at the accepting edge and holds busy for exactly T_STORE edges.
- R6: An accepted direct memory write loads the data into memory at the accepting edge and holds busy for exactly T_STORE edges.
- R7: A store or direct memory write arriving on edges 1 through T_HOLD after reset release is rejected: the pulse is 1, memory is unchanged and busy stays 0. The same request on edge T_HOLD+1 is accepted.
- R8: While write protect is 1, store and direct memory write requests are rejected and memory is unchanged.
- R9: Any request arriving while busy is dropped: the rejected pulse is 1 for one cycle and the wiper and memory are not affected.
- R10: Requests arriving in the same idle cycle are served in the order restore, store, direct memory write, wiper write. Only the first is acted on, and the rest raise the rejected pulse.
- R11: The tolerance output shows byte 0 (sign and integer) when the select is 0 and byte 1 (fraction) when it is 1. Stores never change these bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wpEn | input | 1 | Write protect for the memory copy |
| restoreReq | input | 1 | Restore strobe |
| storeReq | input | 1 | Store strobe |
| nvWrEn | input | 1 | Direct memory write strobe |
| nvWrData | input | W | Direct memory write data |
| wiperWrEn | input | 1 | Wiper write strobe |
| wiperWrData | input | W | Wiper write data |
| tolSel | input | 1 | Tolerance byte select |
| wiper | output | W | Wiper value |
| nvValue | output | W | Memory copy value |
| busy | output | 1 | Timed operation in progress |
| reqRejected | output | 1 | One-cycle pulse for a dropped request |
| tolByte | output | 8 | Selected tolerance byte |

## Verification
The bench issues wiper writes for all 64 codes. It then tries memory writes and stores on every edge of the hold-off window and on the first edge after it, which pins down an off-by-one in the lock. Busy is sampled on every cycle of each timed operation, and a request is injected mid-operation, so the exact duration of each operation and the dropping of late requests are both checked. Paired simultaneous requests separate the priority order, because a wrongly chosen winner leaves a different value in memory or in the wiper.

// File: rtl/wns_pkg.sv
package wns_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PORLOAD = 2'd1,
    ST_RESTORE = 2'd2,
    ST_STORE   = 2'd3
  } seqStateT;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic writeWiper;
    logic writeNv;
    logic loadNv;
    logic loadWiper;
  } seqStrobeT;
endpackage

// File: rtl/wns_ctrl.sv
module wns_ctrl
  import wns_pkg::*;
#(
  parameter int T_RESTORE = 15000,
  parameter int T_STORE   = 1300000,
  parameter int T_HOLD    = 27000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wpEn,
  input  logic      restoreReq,
  input  logic      storeReq,
  input  logic      nvWrEn,
  input  logic      wiperWrEn,
  output seqStrobeT strobe,
  output logic      busy,
  output logic      reqRejected
);
  localparam int T_MAX = (T_STORE > T_RESTORE) ? T_STORE : T_RESTORE;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam int HW    = $clog2(T_HOLD + 1);

  seqStateT        state, stateNxt;
  logic [CW-1:0]   cnt, cntNxt, lastCnt;
  logic [HW-1:0]   holdCnt;
  logic            locked, nvBlock, anyReq, selOk, rejNxt;
  logic [2:0]      nReq;

  assign locked  = (holdCnt != HW'(T_HOLD));
  assign nvBlock = locked | wpEn;
  assign anyReq  = restoreReq | storeReq | nvWrEn | wiperWrEn;
  assign nReq    = 3'(restoreReq) + 3'(storeReq) + 3'(nvWrEn) + 3'(wiperWrEn);
  assign busy    = (state != ST_IDLE);
  assign lastCnt = (state == ST_STORE) ? CW'(T_STORE - 1) : CW'(T_RESTORE - 1);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    cntNxt   = cnt + 1'b1;
    selOk    = 1'b1;
    if (state == ST_IDLE) begin
      cntNxt = '0;
      if (restoreReq) begin
        stateNxt = ST_RESTORE;
      end else if (storeReq) begin
        if (nvBlock) selOk = 1'b0;
        else begin
          strobe.loadNv = 1'b1;
          stateNxt      = ST_STORE;
        end
      end else if (nvWrEn) begin
        if (nvBlock) selOk = 1'b0;
        else begin
          strobe.writeNv = 1'b1;
          stateNxt       = ST_STORE;
        end
      end else if (wiperWrEn) begin
        strobe.writeWiper = 1'b1;
      end
    end else if (cnt == lastCnt) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
      if (state != ST_STORE) strobe.loadWiper = 1'b1;
    end
  end

  assign rejNxt = anyReq & (busy | (nReq > 3'd1) | ~selOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_PORLOAD;
      cnt         <= '0;
      holdCnt     <= '0;
      reqRejected <= 1'b0;
    end else begin
      state       <= stateNxt;
      cnt         <= cntNxt;
      reqRejected <= rejNxt;
      if (locked) holdCnt <= holdCnt + 1'b1;
    end
  end

  p_busy_drops_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyReq) |=> reqRejected);
  p_locked_no_nvwrite_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !(strobe.writeNv || strobe.loadNv));
  p_wp_no_nvwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    wpEn |-> !(strobe.writeNv || strobe.loadNv));
  p_hold_monotonic_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt >= $past(holdCnt));
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/wns_datapath.sv
module wns_datapath
  import wns_pkg::*;
#(
  parameter int              W         = 6,
  parameter logic [W-1:0]    NV_INIT   = W'(1) << (W - 1),
  parameter int              TOL_N     = 2,
  parameter logic [TOL_N*8-1:0] TOL_BYTES = {8'h00, 8'h00}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobeT                 strobe,
  input  logic [W-1:0]              nvWrData,
  input  logic [W-1:0]              wiperWrData,
  input  logic [$clog2(TOL_N)-1:0]  tolSel,
  output logic [W-1:0]              wiper,
  output logic [W-1:0]              nvValue,
  output logic [7:0]                tolByte
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [7:0] tolMem [TOL_N];

  generate
    for (genvar g = 0; g < TOL_N; g++) begin : g_tol
      assign tolMem[g] = TOL_BYTES[g*8 +: 8];
    end
  endgenerate

  assign tolByte = tolMem[tolSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiper   <= MID;
      nvValue <= NV_INIT;
    end else begin
      if (strobe.writeWiper)     wiper <= wiperWrData;
      else if (strobe.loadWiper) wiper <= nvValue;
      if (strobe.writeNv)        nvValue <= nvWrData;
      else if (strobe.loadNv)    nvValue <= wiper;
    end
  end

  p_nv_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.writeNv || strobe.loadNv) |=> $stable(nvValue));
  p_restore_copies_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWiper |=> (wiper == $past(nvValue)));
  p_wiper_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.writeWiper || strobe.loadWiper) |=> $stable(wiper));
endmodule

// File: rtl/wiper_nv_sequencer.sv
module wiper_nv_sequencer
  import wns_pkg::*;
#(
  parameter int              W         = 6,
  parameter int              T_RESTORE = 15000,
  parameter int              T_STORE   = 1300000,
  parameter int              T_HOLD    = 27000,
  parameter logic [W-1:0]    NV_INIT   = W'(1) << (W - 1),
  parameter logic [15:0]     TOL_BYTES = 16'h0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wpEn,
  input  logic         restoreReq,
  input  logic         storeReq,
  input  logic         nvWrEn,
  input  logic [W-1:0] nvWrData,
  input  logic         wiperWrEn,
  input  logic [W-1:0] wiperWrData,
  input  logic         tolSel,
  output logic [W-1:0] wiper,
  output logic [W-1:0] nvValue,
  output logic         busy,
  output logic         reqRejected,
  output logic [7:0]   tolByte
);
  seqStrobeT strobe;

  wns_ctrl #(.T_RESTORE(T_RESTORE), .T_STORE(T_STORE), .T_HOLD(T_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .wpEn(wpEn), .restoreReq(restoreReq),
    .storeReq(storeReq), .nvWrEn(nvWrEn), .wiperWrEn(wiperWrEn),
    .strobe(strobe), .busy(busy), .reqRejected(reqRejected)
  );

  wns_datapath #(.W(W), .NV_INIT(NV_INIT), .TOL_N(2), .TOL_BYTES(TOL_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nvWrData(nvWrData),
    .wiperWrData(wiperWrData), .tolSel(tolSel), .wiper(wiper),
    .nvValue(nvValue), .tolByte(tolByte)
  );
endmodule

// File: tb/sim_wiper_nv_sequencer.sv
module sim_wiper_nv_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 6;
  localparam int TR = 5;
  localparam int TS = 12;
  localparam int TH = 20;
  localparam int NVI = 13;
  localparam int MID = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpEn = 1'b0, restoreReq = 1'b0, storeReq = 1'b0, nvWrEn = 1'b0, wiperWrEn = 1'b0;
  logic [W-1:0] nvWrData = '0, wiperWrData = '0;
  logic tolSel = 1'b0;
  logic [W-1:0] wiper, nvValue;
  logic busy, reqRejected;
  logic [7:0] tolByte;
  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_nv_sequencer #(.W(W), .T_RESTORE(TR), .T_STORE(TS), .T_HOLD(TH),
    .NV_INIT(6'(NVI)), .TOL_BYTES(16'hA53C)) u0 (
    .clk(clk), .rstN(rstN), .wpEn(wpEn), .restoreReq(restoreReq),
    .storeReq(storeReq), .nvWrEn(nvWrEn), .nvWrData(nvWrData),
    .wiperWrEn(wiperWrEn), .wiperWrData(wiperWrData), .tolSel(tolSel),
    .wiper(wiper), .nvValue(nvValue), .busy(busy),
    .reqRejected(reqRejected), .tolByte(tolByte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  // mask: 1 wiper write, 2 memory write, 4 store, 8 restore
  task automatic op(input int mask, input int d, input bit expRej, input int busyLen,
                    input int holdW, input bit poke, input string req);
    wiperWrEn  = mask[0];
    nvWrEn     = mask[1];
    storeReq   = mask[2];
    restoreReq = mask[3];
    wiperWrData = W'(d);
    nvWrData    = W'(d);
    @(negedge clk);
    {wiperWrEn, nvWrEn, storeReq, restoreReq} = '0;
    chk(reqRejected == expRej, req, int'(reqRejected), int'(expRej));
    chk(busy == (busyLen > 0), req, int'(busy), int'(busyLen > 0));
    for (int i = 1; i <= busyLen; i++) begin
      if (poke && i == 1) begin
        wiperWrEn = 1'b1; wiperWrData = W'(63 - d); restoreReq = 1'b1;
      end
      @(negedge clk);
      if (poke && i == 1) begin
        wiperWrEn = 1'b0; restoreReq = 1'b0;
        chk(reqRejected == 1'b1, "R9", int'(reqRejected), 1);
      end
      chk(busy == (i < busyLen), req, int'(busy), int'(i < busyLen));
      if (holdW >= 0 && i < busyLen) chk(wiper == W'(holdW), req, int'(wiper), holdW);
    end
  endtask

  initial begin
    int limit = 0;
    forever begin
      @(posedge clk);
      limit++;
      if (limit > 200000) begin
        nRun++; nFail++;
        $display("FAIL watchdog: actual %0d expected %0d", limit, 200000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wiper == W'(MID), "R1", int'(wiper), MID);
    chk(nvValue == W'(NVI), "R1", int'(nvValue), NVI);
    chk(busy == 1'b1, "R1", int'(busy), 1);
    chk(reqRejected == 1'b0, "R1", int'(reqRejected), 0);
    rstN = 1'b1;
    // R2 power-on restore, one check per edge
    for (int k = 1; k <= TR; k++) begin
      @(negedge clk);
      chk(busy == (k < TR), "R2", int'(busy), int'(k < TR));
      chk(wiper == W'((k < TR) ? MID : NVI), "R2", int'(wiper), (k < TR) ? MID : NVI);
    end
    // R7 hold-off sweep: edges TR+1 .. TH are rejected
    for (int e = TR + 1; e <= TH; e++) begin
      op((e % 2) ? 2 : 4, e, 1'b1, 0, -1, 1'b0, "R7");
      chk(nvValue == W'(NVI), "R7", int'(nvValue), NVI);
    end
    // R6/R7 first edge after hold-off accepts, with a busy poke (R9)
    op(2, 7, 1'b0, TS, NVI, 1'b1, "R6");
    chk(nvValue == W'(7), "R6", int'(nvValue), 7);
    chk(wiper == W'(NVI), "R9", int'(wiper), NVI);
    // R3 exhaustive wiper writes
    for (int v = 0; v < 64; v++) begin
      op(1, v, 1'b0, 0, -1, 1'b0, "R3");
      chk(wiper == W'(v), "R3", int'(wiper), v);
    end
    // R5 store with busy poke
    op(1, 45, 1'b0, 0, -1, 1'b0, "R3");
    op(4, 0, 1'b0, TS, 45, 1'b1, "R5");
    chk(nvValue == W'(45), "R5", int'(nvValue), 45);
    chk(wiper == W'(45), "R9", int'(wiper), 45);
    // R4 restore
    op(1, 9, 1'b0, 0, -1, 1'b0, "R3");
    op(8, 0, 1'b0, TR, 9, 1'b0, "R4");
    chk(wiper == W'(45), "R4", int'(wiper), 45);
    // R8 write protect
    wpEn = 1'b1;
    op(1, 22, 1'b0, 0, -1, 1'b0, "R3");
    op(4, 0, 1'b1, 0, -1, 1'b0, "R8");
    chk(nvValue == W'(45), "R8", int'(nvValue), 45);
    op(2, 2, 1'b1, 0, -1, 1'b0, "R8");
    chk(nvValue == W'(45), "R8", int'(nvValue), 45);
    op(8, 0, 1'b0, TR, 22, 1'b0, "R4");
    chk(wiper == W'(45), "R4", int'(wiper), 45);
    wpEn = 1'b0;
    // R10 priority
    op(1, 10, 1'b0, 0, -1, 1'b0, "R3");
    op(12, 0, 1'b1, TR, 10, 1'b0, "R10");
    chk(wiper == W'(45), "R10", int'(wiper), 45);
    chk(nvValue == W'(45), "R10", int'(nvValue), 45);
    op(1, 20, 1'b0, 0, -1, 1'b0, "R3");
    op(6, 3, 1'b1, TS, 20, 1'b0, "R10");
    chk(nvValue == W'(20), "R10", int'(nvValue), 20);
    op(3, 50, 1'b1, TS, 20, 1'b0, "R10");
    chk(nvValue == W'(50), "R10", int'(nvValue), 50);
    chk(wiper == W'(20), "R10", int'(wiper), 20);
    // R11 tolerance bytes
    tolSel = 1'b0; #1;
    chk(tolByte == 8'h3C, "R11", int'(tolByte), 8'h3C);
    tolSel = 1'b1; #1;
    chk(tolByte == 8'hA5, "R11", int'(tolByte), 8'hA5);
    @(negedge clk);
    summary();
  end
endmodule